// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit path from a ring of buffer descriptors kept in a shared memory. Each time the host asserts the demand pulse while the controller is enabled, the walker reads descriptors one after another. For each one it gathers the bytes of the data buffer the descriptor points to and appends them to the frame it is assembling. When it reaches a descriptor flagged as the end of a frame, it closes that frame on an output byte stream. After every buffer it clears the descriptor's ownership bit and writes the first descriptor word back. This hands the buffer back to software.

The walk stops at the first descriptor that software has not marked ready. It also stops once a fixed number of descriptors has been handled in one demand. The current ring position is kept from one demand to the next. A descriptor with the wrap flag sends the walker back to the ring start. Frames that would grow past the maximum frame size are cut short, and a babble event is reported. Dropping the enable aborts any walk and rewinds the position to the ring start.

Top module: `txring_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `memEn`, `txValid` and the three event pulses are all low.
- R2: A demand pulse while `ctrlEnable` is low is ignored. `busy` stays low, no memory access happens and no descriptor changes.
- R3: A descriptor is two little-endian 32-bit words at an 8-byte aligned address. Word 0 holds the buffer length in bits 15:0, the ready flag in bit 31, the wrap flag in bit 29 and the end-of-frame flag in bit 27. Word 1 is the buffer's byte address. Byte k of a memory word occupies bits 8k+7:8k.
- R4: The walk ends at the first descriptor whose ready flag is clear, and `busy` falls. The next honoured demand starts at that same descriptor.
- R5: Buffer bytes are emitted in address order, buffer after buffer, as one frame. The frame's final byte carries `txLast`, and `txLast` appears nowhere else.
- R6: Every processed descriptor has word 0 written back with bit 31 cleared and all other bits unchanged, and it raises a one-cycle `bufDone`.
- R7: An end-of-frame descriptor raises `frameDone` in the same cycle as its `bufDone` and starts a new frame accumulation.
- R8: If a buffer would push the frame beyond MAX_FRAME bytes, only the bytes up to MAX_FRAME are taken and `babbleErr` pulses with that descriptor's `bufDone`.
- R9: After a descriptor with the wrap flag the next descriptor is the ring start. Otherwise it is the current address plus 8.
- R10: One demand handles at most MAX_DESC descriptors. The walk then ends with the position kept at the next descriptor, and a later demand continues from there.
- R11: While `ctrlEnable` is low, the current descriptor address is held at the ring start. The ring start register forces its three low address bits to zero.
- R12: `busy` is high from the cycle after an honoured demand until the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlEnable | input | 1 | Controller enable level; low aborts and rewinds |
| kick | input | 1 | Transmit demand pulse |
| ringBaseWe | input | 1 | Write strobe for the ring start register |
| ringBaseIn | input | ADDR_W | Ring start byte address (low 3 bits dropped) |
| busy | output | 1 | Demand in progress; low once the walk ends |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (else read) |
| memAddr | output | ADDR_W | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid one cycle after a read request |
| txValid | output | 1 | Frame byte valid |
| txData | output | 8 | Frame byte |
| txLast | output | 1 | Final byte of the frame |
| bufDone | output | 1 | One-cycle pulse per processed descriptor |
| frameDone | output | 1 | One-cycle pulse per completed frame |
| babbleErr | output | 1 | One-cycle pulse when a buffer was cut at the frame limit |

## Verification
The interesting collision is a buffer that both ends a frame and overruns the size limit. In that one write-back cycle `bufDone`, `frameDone` and `babbleErr` all rise together, and the truncated frame's final byte must still carry `txLast`. The bench provokes this with two buffers whose combined length exceeds MAX_FRAME, the second flagged as end of frame. It counts the cycles in which all three pulses coincide and checks that the scoreboard received exactly MAX_FRAME bytes with the marker on the last one. A second overlap, wrap combined with end of frame, is checked through the address of the descriptor that is fetched next.

// File: rtl/txring_pkg.sv
package txring_pkg;

  localparam int LEN_W      = 16;
  localparam int WORD_W     = 32;
  localparam int READY_BIT  = 31;
  localparam int WRAP_BIT   = 29;
  localparam int LAST_BIT   = 27;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_FETCH2,
    ST_XFER,
    ST_WBACK
  } walkState_e;

  typedef struct packed {
    logic startKick;
    logic rdWord0;
    logic capWord0;
    logic capPtr;
    logic issueByte;
    logic writeBack;
    logic abort;
  } walkStrobe_t;

endpackage

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlEnable,
  input  logic        kick,
  input  logic        word0Ready,
  input  logic        remainZero,
  input  logic        rdPending,
  input  logic        lastOfKick,
  output walkStrobe_t strobe,
  output logic        busy
);

  walkState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (!ctrlEnable) begin
      strobe.abort = 1'b1;
      stateNext    = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (kick) begin
            strobe.startKick = 1'b1;
            stateNext        = ST_FETCH0;
          end
        end
        ST_FETCH0: begin
          strobe.rdWord0 = 1'b1;
          stateNext      = ST_FETCH1;
        end
        ST_FETCH1: begin
          if (word0Ready) begin
            strobe.capWord0 = 1'b1;
            stateNext       = ST_FETCH2;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_FETCH2: begin
          strobe.capPtr = 1'b1;
          stateNext     = ST_XFER;
        end
        ST_XFER: begin
          if (!remainZero) begin
            strobe.issueByte = 1'b1;
          end else if (!rdPending) begin
            stateNext = ST_WBACK;
          end
        end
        ST_WBACK: begin
          strobe.writeBack = 1'b1;
          stateNext        = lastOfKick ? ST_IDLE : ST_FETCH0;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R2
  kick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && kick && !ctrlEnable) |=> (state == ST_IDLE));

  // R4
  stop_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH1 && !word0Ready) |=> (state == ST_IDLE));

  // R12
  busy_after_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && kick && ctrlEnable) |=> busy);

endmodule

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2047,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              ringBaseWe,
  input  logic [ADDR_W-1:0] ringBaseIn,
  input  walkStrobe_t       strobe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              word0Ready,
  output logic              remainZero,
  output logic              rdPending,
  output logic              lastOfKick,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              bufDone,
  output logic              frameDone,
  output logic              babbleErr
);

  localparam int FLEN_W = $clog2(MAX_FRAME + 1);
  localparam int CNT_W  = $clog2(MAX_DESC + 1);

  logic [ADDR_W-1:0] ringBase, curDesc, bufPtr;
  logic [WORD_W-1:0] word0Q;
  logic [LEN_W-1:0]  remain;
  logic [FLEN_W-1:0] frameLen;
  logic [CNT_W-1:0]  descCount;
  logic              babbleQ, rdPendQ, holdValid;
  logic [1:0]        laneQ;
  logic [7:0]        holdByte, rxByte;

  // room left in the frame and length actually taken from this buffer
  logic [LEN_W:0]    roomW, lenW;
  logic              overrun;
  logic [LEN_W-1:0]  takeLen;

  always_comb begin
    roomW   = (LEN_W+1)'(MAX_FRAME) - (LEN_W+1)'(frameLen);
    lenW    = {1'b0, word0Q[LEN_W-1:0]};
    overrun = (lenW > roomW);
    takeLen = overrun ? roomW[LEN_W-1:0] : word0Q[LEN_W-1:0];
  end

  assign rxByte     = memRdata[{laneQ, 3'b000} +: 8];
  assign word0Ready = memRdata[READY_BIT];
  assign remainZero = (remain == '0);
  assign rdPending  = rdPendQ;
  assign lastOfKick = (descCount == CNT_W'(MAX_DESC - 1));

  // memory port
  always_comb begin
    memEn    = strobe.rdWord0 | strobe.capWord0 | strobe.issueByte | strobe.writeBack;
    memWe    = strobe.writeBack;
    memWdata = word0Q & ~(WORD_W'(1) << READY_BIT);
    if (strobe.rdWord0 || strobe.writeBack)
      memAddr = curDesc;
    else if (strobe.capWord0)
      memAddr = curDesc + ADDR_W'(4);
    else
      memAddr = {bufPtr[ADDR_W-1:2], 2'b00};
  end

  assign bufDone   = strobe.writeBack;
  assign frameDone = strobe.writeBack & word0Q[LAST_BIT];
  assign babbleErr = strobe.writeBack & babbleQ;

  // ring start register
  always_ff @(posedge clk) begin
    if (!rstN)           ringBase <= '0;
    else if (ringBaseWe) ringBase <= {ringBaseIn[ADDR_W-1:3], 3'b000};
  end

  // descriptor walk state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc   <= '0;
      word0Q    <= '0;
      bufPtr    <= '0;
      remain    <= '0;
      frameLen  <= '0;
      descCount <= '0;
      babbleQ   <= 1'b0;
      rdPendQ   <= 1'b0;
      laneQ     <= '0;
    end else if (strobe.abort) begin
      curDesc  <= ringBase;
      frameLen <= '0;
      remain   <= '0;
      rdPendQ  <= 1'b0;
      babbleQ  <= 1'b0;
    end else begin
      rdPendQ <= strobe.issueByte;
      if (strobe.startKick) descCount <= '0;
      if (strobe.capWord0)  word0Q <= memRdata;
      if (strobe.capPtr) begin
        bufPtr   <= memRdata[ADDR_W-1:0];
        remain   <= takeLen;
        babbleQ  <= overrun;
        frameLen <= frameLen + FLEN_W'(takeLen);
      end
      if (strobe.issueByte) begin
        laneQ  <= bufPtr[1:0];
        bufPtr <= bufPtr + ADDR_W'(1);
        remain <= remain - LEN_W'(1);
      end
      if (strobe.writeBack) begin
        descCount <= descCount + CNT_W'(1);
        curDesc   <= word0Q[WRAP_BIT] ? ringBase : curDesc + ADDR_W'(DESC_BYTES);
        if (word0Q[LAST_BIT]) frameLen <= '0;
      end
    end
  end

  // byte stream: one byte held back so the end marker lands on the final byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdByte  <= '0;
      txValid   <= 1'b0;
      txData    <= '0;
      txLast    <= 1'b0;
    end else begin
      txValid <= 1'b0;
      txLast  <= 1'b0;
      if (strobe.abort) begin
        holdValid <= 1'b0;
      end else if (rdPendQ) begin
        if (holdValid) begin
          txValid <= 1'b1;
          txData  <= holdByte;
        end
        holdByte  <= rxByte;
        holdValid <= 1'b1;
      end else if (strobe.writeBack && word0Q[LAST_BIT] && holdValid) begin
        txValid   <= 1'b1;
        txData    <= holdByte;
        txLast    <= 1'b1;
        holdValid <= 1'b0;
      end
    end
  end

  // R6
  wb_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> !memWdata[READY_BIT]);

  // R11
  desc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    curDesc[2:0] == 3'b000);

  // R11
  disabled_rewind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> (curDesc == $past(ringBase)));

  // R8
  frame_len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameLen <= FLEN_W'(MAX_FRAME));

  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  // R9
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeBack && word0Q[WRAP_BIT]) |=> (curDesc == $past(ringBase)));

  // R10
  kick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    descCount <= CNT_W'(MAX_DESC));

endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2047,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              kick,
  input  logic              ringBaseWe,
  input  logic [ADDR_W-1:0] ringBaseIn,
  output logic              busy,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              bufDone,
  output logic              frameDone,
  output logic              babbleErr
);

  walkStrobe_t strobe;
  logic word0Ready, remainZero, rdPending, lastOfKick;

  txring_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlEnable),
    .kick       (kick),
    .word0Ready (word0Ready),
    .remainZero (remainZero),
    .rdPending  (rdPending),
    .lastOfKick (lastOfKick),
    .strobe     (strobe),
    .busy       (busy)
  );

  txring_datapath #(
    .ADDR_W    (ADDR_W),
    .MAX_FRAME (MAX_FRAME),
    .MAX_DESC  (MAX_DESC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlEnable),
    .ringBaseWe (ringBaseWe),
    .ringBaseIn (ringBaseIn),
    .strobe     (strobe),
    .memRdata   (memRdata),
    .word0Ready (word0Ready),
    .remainZero (remainZero),
    .rdPending  (rdPending),
    .lastOfKick (lastOfKick),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .txValid    (txValid),
    .txData     (txData),
    .txLast     (txLast),
    .bufDone    (bufDone),
    .frameDone  (frameDone),
    .babbleErr  (babbleErr)
  );

endmodule

// File: tb/txring_walker_bench.sv
`timescale 1ns/1ps
module txring_walker_bench;

  localparam int ADDR_W    = 32;
  localparam int MAX_FRAME = 40;
  localparam int MAX_DESC  = 6;
  localparam int BASE      = 32'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEnable = 1'b0;
  logic kick = 1'b0;
  logic ringBaseWe = 1'b0;
  logic [ADDR_W-1:0] ringBaseIn = '0;
  logic busy, memEn, memWe, txValid, txLast, bufDone, frameDone, babbleErr;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic [7:0]  txData;

  always #2.5 clk = ~clk;

  txring_walker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)) u_txring_walker (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .kick(kick),
    .ringBaseWe(ringBaseWe), .ringBaseIn(ringBaseIn), .busy(busy),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .txValid(txValid), .txData(txData), .txLast(txLast),
    .bufDone(bufDone), .frameDone(frameDone), .babbleErr(babbleErr));

  // memory model, 1-cycle read latency
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else       memRdata <= mem[memAddr[11:2]];
    end
  end

  // scoreboard
  logic [8:0] expQ [$];
  int checks = 0, fails = 0, monChecks = 0, monFails = 0;
  int bufCnt = 0, frameCnt = 0, babCnt = 0, coinc = 0, memAcc = 0;
  int benchAcc = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (memEn) memAcc++;
      if (bufDone) bufCnt++;
      if (frameDone) frameCnt++;
      if (babbleErr) babCnt++;
      if (babbleErr && frameDone && bufDone) coinc++;
      if (txValid) begin
        monChecks++;
        if (expQ.size() == 0) begin
          monFails++;
          $display("FAIL R5 unexpected byte act=%0h last=%0b exp=none", txData, txLast);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          if ({txData, txLast} !== e) begin
            monFails++;
            $display("FAIL R5 stream byte act=%0h/%0b exp=%0h/%0b", txData, txLast, e[8:1], e[0]);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic setDesc(int idx, int len, bit rdy, bit wrp, bit lst, int ptr);
    int a;
    a = BASE + idx * 8;
    mem[(a >> 2) & 1023]       <= {rdy, 1'b0, wrp, 1'b0, lst, 11'b0, len[15:0]};
    mem[((a >> 2) + 1) & 1023] <= ptr;
  endtask

  task automatic armDesc(int idx, int len, bit wrp, bit lst, int ptr, int seed);
    setDesc(idx, len, 1'b1, wrp, lst, ptr);
    for (int i = 0; i < len; i++) begin
      int p;
      p = ptr + i;
      mem[(p >> 2) & 1023][8 * (p % 4) +: 8] <= 8'(seed + i);
    end
  endtask

  task automatic expectBuf(int len, bit lst, int seed);
    int room, take;
    room = MAX_FRAME - benchAcc;
    take = (len > room) ? room : len;
    for (int i = 0; i < take; i++) expQ.push_back({8'(seed + i), 1'b0});
    benchAcc += take;
    if (lst) begin
      if (benchAcc > 0) expQ[expQ.size() - 1][0] = 1'b1;
      benchAcc = 0;
    end
  endtask

  function automatic logic [31:0] word0Of(int idx);
    return mem[((BASE + idx * 8) >> 2) & 1023];
  endfunction

  task automatic doKick(string req, bit expectBusy);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    check(busy == expectBusy, req, busy, expectBusy);
  endtask

  task automatic waitIdle(string req);
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check(!busy, req, busy, 0);
    repeat (4) @(negedge clk);
  endtask

  int b0, f0, k0, c0, m0;
  task automatic snap();
    b0 = bufCnt; f0 = frameCnt; k0 = babCnt; c0 = coinc; m0 = memAcc;
  endtask

  task automatic checkCounts(string tag, int eb, int ef, int ek);
    check(bufCnt - b0 == eb, {tag, " R6 bufDone count"}, bufCnt - b0, eb);
    check(frameCnt - f0 == ef, {tag, " R7 frameDone count"}, frameCnt - f0, ef);
    check(babCnt - k0 == ek, {tag, " R8 babble count"}, babCnt - k0, ek);
    check(expQ.size() == 0, {tag, " R5 all bytes seen"}, expQ.size(), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks + monChecks, fails + monFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy", busy, 0);
    check(!memEn, "R1 memEn", memEn, 0);
    check(!txValid && !bufDone && !frameDone && !babbleErr, "R1 outputs", txValid, 0);

    // ring start with low bits set: must be dropped (R11)
    ringBaseIn = 32'h105; ringBaseWe = 1'b1;
    @(negedge clk); ringBaseWe = 1'b0;

    // R2: demand while disabled
    armDesc(0, 5, 0, 1, 32'h401, 8'h10);
    @(negedge clk);
    snap();
    doKick("R2 busy stays low", 1'b0);
    repeat (10) @(negedge clk);
    check(memAcc == m0, "R2 no memory access", memAcc - m0, 0);
    check(word0Of(0) == 32'h8800_0005, "R2 descriptor untouched", word0Of(0), 32'h8800_0005);

    ctrlEnable = 1'b1;
    repeat (2) @(negedge clk);

    // single-buffer frame, unaligned pointer (R3, R6, R11, R12)
    expectBuf(5, 1, 8'h10);
    snap();
    doKick("R12 busy after kick", 1'b1);
    waitIdle("R4 walk ends");
    checkCounts("T2", 1, 1, 0);
    check(word0Of(0) == 32'h0800_0005, "R6 R3 writeback word", word0Of(0), 32'h0800_0005);

    // multi-buffer frame stops at not-ready descriptor (R5, R4)
    armDesc(1, 3, 0, 0, 32'h480, 8'h20);
    armDesc(2, 4, 0, 1, 32'h4A2, 8'h30);
    @(negedge clk);
    expectBuf(3, 0, 8'h20);
    expectBuf(4, 1, 8'h30);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R4 stop");
    checkCounts("T3", 2, 1, 0);
    check(word0Of(1) == 32'h0000_0003, "R6 desc1 writeback", word0Of(1), 32'h0000_0003);

    // resume at the stopped descriptor (R4)
    armDesc(3, 2, 0, 1, 32'h4C0, 8'h40);
    @(negedge clk);
    expectBuf(2, 1, 8'h40);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R4 resume");
    checkCounts("T4 R4", 1, 1, 0);

    // wrap combined with end of frame (R9)
    armDesc(4, 1, 1, 1, 32'h4D0, 8'h50);
    armDesc(0, 2, 0, 1, 32'h4E0, 8'h60);
    armDesc(5, 1, 0, 1, 32'h4F0, 8'h70);
    @(negedge clk);
    expectBuf(1, 1, 8'h50);
    expectBuf(2, 1, 8'h60);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R9 walk ends");
    checkCounts("T5 R9", 2, 2, 0);
    check(word0Of(5)[31], "R9 descriptor after wrap-flagged one skipped", word0Of(5), 32'h8800_0001);
    setDesc(5, 0, 0, 0, 0, 0);

    // truncation at the frame limit (R8, R7 coincidence)
    armDesc(1, 30, 0, 0, 32'h500, 8'h80);
    armDesc(2, 20, 0, 1, 32'h540, 8'hA0);
    @(negedge clk);
    expectBuf(30, 0, 8'h80);
    expectBuf(20, 1, 8'hA0);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R8 walk ends");
    checkCounts("T6 R8", 2, 1, 1);
    check(coinc - c0 == 1, "R8 R7 babble with frameDone and bufDone", coinc - c0, 1);

    // per-demand bound (R10)
    for (int i = 3; i < 8; i++) armDesc(i, 1, (i == 7), 1, 32'h600 + i * 4, 8'hC0 + i);
    armDesc(0, 1, 0, 1, 32'h640, 8'hD0);
    armDesc(1, 1, 0, 1, 32'h644, 8'hD1);
    @(negedge clk);
    for (int i = 3; i < 8; i++) expectBuf(1, 1, 8'hC0 + i);
    expectBuf(1, 1, 8'hD0);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R10 walk ends");
    checkCounts("T7 R10", 6, 6, 0);
    check(word0Of(1)[31], "R10 descriptor beyond bound still ready", word0Of(1), 32'h8800_0001);
    expectBuf(1, 1, 8'hD1);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R10 continue");
    checkCounts("T7b R10", 1, 1, 0);

    // disable rewinds to ring start (R11)
    ctrlEnable = 1'b0;
    repeat (2) @(negedge clk);
    ctrlEnable = 1'b1;
    armDesc(0, 3, 0, 1, 32'h700, 8'hE0);
    @(negedge clk);
    expectBuf(3, 1, 8'hE0);
    snap();
    doKick("R12 busy", 1'b1);
    waitIdle("R11 walk ends");
    checkCounts("T8 R11", 1, 1, 0);

    finishRun();
  end

endmodule